// File: doc/BRIEF.md
# Indexed Block Configuration Register Slave

This block is a two-wire serial slave that gives a host access to a bank of byte-wide configuration registers. The host opens a transfer with its write address, sends a starting register offset, and then either writes a byte count followed by that many data bytes, or turns the bus round with a repeated start and the read address. On a read the slave sends a byte count of its own and then streams register contents from the chosen offset until the host refuses a byte and stops. After every data byte the offset steps on by one and wraps at the top of the bank.

Each register has its own power-on value and a per-bit read-only mask. A register that holds an identity code cannot be changed at all. Two others mix read-only status bits with writable bits. A band of placeholder locations acknowledges writes but keeps nothing. SCL and SDA are oversampled on the system clock. SDA is driven only low, through `sdaOe`. The whole register image is exposed in parallel on `cfgFlat`, where register i sits at bits [8i+7:8i].

Top module: `smbus_idx_slave`

## Requirements
- R1: After reset SDA is released and the registers hold their defaults: 0 to 2 = FFh, 3 = A0h, 6 = 40h, 7 (identity) = 21h, 8 (read count) = 1Fh (NUM_REGS-1), all others 00h.
- R2: Address byte D2h (write) or D3h (read) is acknowledged (SDA low in the ninth clock). Any other address is not acknowledged, and every byte up to the next start is refused and changes nothing.
- R3: A write transfer (D2h, offset, count N, N data bytes) stores the data bytes in consecutive registers from the offset and acknowledges each one.
- R4: A count byte of 00h is not acknowledged, and the slave then ignores the rest of the transfer.
- R5: Data bytes beyond the announced count are not acknowledged and are not stored.
- R6: After D2h, offset, repeated start and D3h, the slave first sends the contents of register 8 as the byte count, then the register contents from the offset upward, MSB first.
- R7: The host ends a read early by leaving a byte unacknowledged and sending a stop. The next transfer then works normally.
- R8: Read-only bits keep their values under writes: all of register 7, bits 7:5 of register 3, and bits 7:6 of register 6. The other bits of those registers take the written value.
- R9: Registers 9 to 16 acknowledge written bytes, store nothing and read as 00h.
- R10: The offset wraps from NUM_REGS-1 to 0 on both writes and reads.
- R11: A data byte is stored only once its acknowledge clock has completed. A byte cut short by a stop is dropped.
- R12: SDA is pulled low only during an acknowledge slot or a read data bit, it changes only while SCL is low, and it is released when the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| cfgFlat | output | NUM_REGS*8 | Parallel image of all registers |

## Verification
A falling SCL reaches the control logic after two synchroniser stages, so an acknowledge or a read bit appears on `sdaOe` at the third clock edge after the fall. The first bit of a read data byte comes two edges later, because the offset has to step on before the byte is loaded. Stored register values appear on `cfgFlat` one edge after the acknowledge clock falls. The bench master holds each SCL phase for six system clocks. It samples SDA only at the end of the high phase, and reads `cfgFlat` only after a stop, so every result is already settled when it is looked at. The acknowledge bits and read bytes are compared through an expected-value queue, in the order the bus produces them.

// File: rtl/smbus_reg_pkg.sv
package smbus_reg_pkg;

  localparam int SEL_REG  = 3;
  localparam int FLAG_REG = 6;

  typedef struct packed {
    logic       setOffset;
    logic       commitWrite;
    logic       advance;
    logic [7:0] data;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_OFFSET, S_COUNT, S_WDATA, S_RCOUNT, S_RDATA
  } ctrlState_t;

  function automatic logic [7:0] regDefault(int idx, int idReg, logic [7:0] idVal,
                                            int cntReg, int numRegs);
    logic [7:0] v;
    v = 8'h00;
    if (idx <= 2)             v = 8'hFF;
    else if (idx == SEL_REG)  v = 8'hA0;
    else if (idx == FLAG_REG) v = 8'h40;
    if (idx == idReg)         v = idVal;
    if (idx == cntReg)        v = 8'(numRegs - 1);
    return v;
  endfunction

  function automatic logic [7:0] regRoMask(int idx, int idReg);
    logic [7:0] m;
    m = 8'h00;
    if (idx == SEL_REG)  m = 8'hE0;
    if (idx == FLAG_REG) m = 8'hC0;
    if (idx == idReg)    m = 8'hFF;
    return m;
  endfunction

endpackage

// File: rtl/smbus_ctrl.sv
module smbus_ctrl
  import smbus_reg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hD2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] countByte,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output dpStrobe_t  strb
);
  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS, sclRise, sclFall, startDet, stopDet;

  ctrlState_t state, nextSt, decSt;
  logic [3:0] bitIdx;
  logic       ackPhase, txMode, ackGood, masterAck, decGood;
  logic [7:0] shiftReg, txReg, remaining;
  logic [1:0] loadCnt;

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // accept or refuse the byte just received
  always_comb begin
    decGood = 1'b0;
    decSt   = S_IDLE;
    case (state)
      S_ADDR: begin
        if (shiftReg == WR_ADDR) begin decGood = 1'b1; decSt = S_OFFSET; end
        else if (shiftReg == RD_ADDR) begin decGood = 1'b1; decSt = S_RCOUNT; end
      end
      S_OFFSET: begin decGood = 1'b1; decSt = S_COUNT; end
      S_COUNT:  begin decGood = (shiftReg != 8'h00); decSt = S_WDATA; end
      S_WDATA:  begin decGood = (remaining != 8'h00); decSt = S_WDATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11;
      sclPrev <= 1'b1;  sdaPrev <= 1'b1;
      state <= S_IDLE;  nextSt <= S_IDLE;
      bitIdx <= '0; ackPhase <= 1'b0; txMode <= 1'b0;
      ackGood <= 1'b0; masterAck <= 1'b0;
      shiftReg <= '0; txReg <= '0; remaining <= '0;
      loadCnt <= '0; sdaOe <= 1'b0; strb <= '0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      strb    <= '0;
      if (stopDet) begin
        state <= S_IDLE; sdaOe <= 1'b0; ackPhase <= 1'b0;
        loadCnt <= '0; txMode <= 1'b0;
      end else if (startDet) begin
        state <= S_ADDR; bitIdx <= '0; ackPhase <= 1'b0;
        sdaOe <= 1'b0; txMode <= 1'b0; loadCnt <= '0;
      end else if (state != S_IDLE) begin
        if (loadCnt != 2'd0) begin
          loadCnt <= loadCnt - 2'd1;
          if (loadCnt == 2'd1) begin
            txReg <= rdByte;
            sdaOe <= ~rdByte[7];
          end
        end
        if (sclRise) begin
          if (ackPhase) begin
            if (txMode) masterAck <= ~sdaS;
          end else begin
            if (!txMode) shiftReg <= {shiftReg[6:0], sdaS};
            bitIdx <= bitIdx + 4'd1;
          end
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            bitIdx   <= '0;
            sdaOe    <= 1'b0;
            if (txMode) begin
              if (masterAck) begin
                if (state == S_RDATA) strb.advance <= 1'b1;
                state   <= S_RDATA;
                loadCnt <= 2'd2;
              end else begin
                state  <= S_IDLE;
                txMode <= 1'b0;
              end
            end else if (ackGood) begin
              state <= nextSt;
              case (state)
                S_ADDR: if (nextSt == S_RCOUNT) begin
                  txMode <= 1'b1;
                  txReg  <= countByte;
                  sdaOe  <= ~countByte[7];
                end
                S_OFFSET: begin
                  strb.setOffset <= 1'b1;
                  strb.data      <= shiftReg;
                end
                S_COUNT: remaining <= shiftReg;
                S_WDATA: begin
                  strb.commitWrite <= 1'b1;
                  strb.data        <= shiftReg;
                  remaining        <= remaining - 8'd1;
                end
                default: ;
              endcase
            end else begin
              state <= S_IDLE;
            end
          end else if (bitIdx == 4'd8) begin
            ackPhase <= 1'b1;
            if (txMode) begin
              sdaOe <= 1'b0;
            end else begin
              ackGood <= decGood;
              sdaOe   <= decGood;
              nextSt  <= decSt;
            end
          end else if (txMode && bitIdx != 4'd0) begin
            txReg <= {txReg[6:0], 1'b0};
            sdaOe <= ~txReg[6];
          end
        end
      end
    end
  end

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

  // R12
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setOffset, strb.commitWrite, strb.advance}));

  // R11
  commit_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |-> (state == S_WDATA) && !ackPhase);

endmodule

// File: rtl/smbus_regbank.sv
module smbus_regbank
  import smbus_reg_pkg::*;
#(
  parameter int         NUM_REGS  = 32,
  parameter int         ID_REG    = 7,
  parameter logic [7:0] ID_VALUE  = 8'h21,
  parameter int         COUNT_REG = 8,
  parameter int         DUMMY_LO  = 9,
  parameter int         DUMMY_HI  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  output logic [7:0]            rdByte,
  output logic [7:0]            countByte,
  output logic [NUM_REGS*8-1:0] cfgFlat
);
  localparam int AW = $clog2(NUM_REGS);

  logic [AW-1:0] ptr;
  logic [7:0]    regQ [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (strb.setOffset) ptr <= strb.data[AW-1:0];
    else if (strb.commitWrite || strb.advance) ptr <= ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i >= DUMMY_LO && i <= DUMMY_HI) begin : g_dummy
      assign regQ[i] = 8'h00;
    end else begin : g_store
      localparam logic [7:0] DEF = regDefault(i, ID_REG, ID_VALUE, COUNT_REG, NUM_REGS);
      localparam logic [7:0] RO  = regRoMask(i, ID_REG);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= DEF;
        else if (strb.commitWrite && ptr == AW'(i))
          q <= (q & RO) | (strb.data & ~RO);
      end
      assign regQ[i] = q;
    end
    assign cfgFlat[i*8 +: 8] = regQ[i];
  end

  assign rdByte    = regQ[ptr];
  assign countByte = regQ[COUNT_REG];

  // R8
  id_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regQ[ID_REG]));

  // R10
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && ptr == AW'(NUM_REGS - 1)) |=> ptr == '0);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> ptr == $past(ptr) + 1'b1);

endmodule

// File: rtl/smbus_idx_slave.sv
module smbus_idx_slave
  import smbus_reg_pkg::*;
#(
  parameter int         NUM_REGS  = 32,
  parameter logic [7:0] WR_ADDR   = 8'hD2,
  parameter int         ID_REG    = 7,
  parameter logic [7:0] ID_VALUE  = 8'h21,
  parameter int         COUNT_REG = 8,
  parameter int         DUMMY_LO  = 9,
  parameter int         DUMMY_HI  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] cfgFlat
);
  dpStrobe_t  strb;
  logic [7:0] rdByte, countByte;

  smbus_ctrl #(.WR_ADDR(WR_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .countByte(countByte), .rdByte(rdByte), .sdaOe(sdaOe), .strb(strb)
  );

  smbus_regbank #(
    .NUM_REGS(NUM_REGS), .ID_REG(ID_REG), .ID_VALUE(ID_VALUE),
    .COUNT_REG(COUNT_REG), .DUMMY_LO(DUMMY_LO), .DUMMY_HI(DUMMY_HI)
  ) bank_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdByte(rdByte), .countByte(countByte), .cfgFlat(cfgFlat)
  );
endmodule

// File: tb/smbus_idx_slave_tb.sv
module smbus_idx_slave_tb_top;
  localparam int NREG = 32;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  logic [NREG*8-1:0] cfgFlat;
  wire  sdaLine = mSda & ~sdaOe;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [8:0] expQ[$];
  logic [8:0] actQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  smbus_idx_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .cfgFlat(cfgFlat)
  );

  // monitor: pops bus results and compares them in order
  always @(negedge clk) begin
    if (actQ.size() != 0 && expQ.size() != 0) begin
      logic [8:0] a, e;
      string t;
      a = actQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] regAt(int i);
    return cfgFlat[i*8 +: 8];
  endfunction

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; mScl = 1'b1; waitq();
    mSda = 1'b0; waitq();
    mScl = 1'b0; waitq();
  endtask

  task automatic busRestart();
    mSda = 1'b1; waitq();
    mScl = 1'b1; waitq();
    mSda = 1'b0; waitq();
    mScl = 1'b0; waitq();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitq();
    mScl = 1'b1; waitq();
    mSda = 1'b1; waitq();
    waitq();
    chk("R12 SDA released after stop", {31'd0, sdaOe}, 32'd0);
  endtask

  task automatic sendBit(logic b);
    mSda = b; waitq();
    mScl = 1'b1; waitq(); waitq();
    mScl = 1'b0; waitq();
  endtask

  task automatic recvBit(output logic b);
    mSda = 1'b1; waitq();
    mScl = 1'b1; waitq();
    b = sdaLine; waitq();
    mScl = 1'b0; waitq();
  endtask

  // driver: sends a byte and queues the expected acknowledge
  task automatic wrByte(logic [7:0] d, logic expAck, string tag);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(a);
    expQ.push_back({1'b1, 7'd0, expAck});
    tagQ.push_back(tag);
    actQ.push_back({1'b1, 7'd0, ~a});
  endtask

  task automatic rdByte(logic [7:0] exp, logic giveAck, string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    expQ.push_back({1'b0, exp});
    tagQ.push_back(tag);
    actQ.push_back({1'b0, v});
    sendBit(~giveAck);
  endtask

  task automatic rdOpen(logic [7:0] off, logic [7:0] expCnt, string tag);
    busStart();
    wrByte(8'hD2, 1'b1, {tag, " addr"});
    wrByte(off, 1'b1, {tag, " offset"});
    busRestart();
    wrByte(8'hD3, 1'b1, {tag, " read addr"});
    rdByte(expCnt, 1'b1, {tag, " count byte"});
  endtask

  task automatic wrOpen(logic [7:0] off, logic [7:0] cnt, string tag);
    busStart();
    wrByte(8'hD2, 1'b1, {tag, " addr"});
    wrByte(off, 1'b1, {tag, " offset"});
    wrByte(cnt, 1'b1, {tag, " count"});
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 SDA idle", {31'd0, sdaOe}, 32'd0);
    chk("R1 reg0", {24'd0, regAt(0)}, 32'hFF);
    chk("R1 reg3", {24'd0, regAt(3)}, 32'hA0);
    chk("R1 reg7 id", {24'd0, regAt(7)}, 32'h21);
    chk("R1 reg8 count", {24'd0, regAt(8)}, 32'h1F);

    // R6 read of defaults, R7 early stop with a refused byte
    rdOpen(8'h00, 8'h1F, "R6");
    rdByte(8'hFF, 1'b1, "R6 reg0");
    rdByte(8'hFF, 1'b1, "R6 reg1");
    rdByte(8'hFF, 1'b1, "R6 reg2");
    rdByte(8'hA0, 1'b0, "R7 reg3 last");
    busStop();

    // R3 block write, R7 next transfer works
    wrOpen(8'h14, 8'h03, "R3");
    wrByte(8'h11, 1'b1, "R3 data0");
    wrByte(8'h22, 1'b1, "R3 data1");
    wrByte(8'h33, 1'b1, "R3 data2");
    busStop();
    chk("R3 reg20", {24'd0, regAt(20)}, 32'h11);
    chk("R3 reg21", {24'd0, regAt(21)}, 32'h22);
    chk("R3 reg22", {24'd0, regAt(22)}, 32'h33);

    // R5 bytes past the count
    wrOpen(8'h18, 8'h01, "R5");
    wrByte(8'h5A, 1'b1, "R5 data0");
    wrByte(8'h77, 1'b0, "R5 extra refused");
    busStop();
    chk("R5 reg24", {24'd0, regAt(24)}, 32'h5A);
    chk("R5 reg25 untouched", {24'd0, regAt(25)}, 32'h00);

    // R4 zero count
    busStart();
    wrByte(8'hD2, 1'b1, "R4 addr");
    wrByte(8'h1A, 1'b1, "R4 offset");
    wrByte(8'h00, 1'b0, "R4 zero count refused");
    wrByte(8'h99, 1'b0, "R4 later byte refused");
    busStop();
    chk("R4 reg26 untouched", {24'd0, regAt(26)}, 32'h00);

    // R2 foreign address
    busStart();
    wrByte(8'hA0, 1'b0, "R2 foreign addr refused");
    wrByte(8'h05, 1'b0, "R2 following byte refused");
    busStop();
    chk("R2 reg5 untouched", {24'd0, regAt(5)}, 32'h00);

    // R8 read-only bits
    wrOpen(8'h03, 8'h05, "R8");
    wrByte(8'hFF, 1'b1, "R8 reg3");
    wrByte(8'hAB, 1'b1, "R8 reg4");
    wrByte(8'hCD, 1'b1, "R8 reg5");
    wrByte(8'hFF, 1'b1, "R8 reg6");
    wrByte(8'h00, 1'b1, "R8 reg7");
    busStop();
    chk("R8 reg3 mixed", {24'd0, regAt(3)}, 32'hBF);
    chk("R8 reg4", {24'd0, regAt(4)}, 32'hAB);
    chk("R8 reg6 mixed", {24'd0, regAt(6)}, 32'h7F);
    chk("R8 reg7 id kept", {24'd0, regAt(7)}, 32'h21);

    // R9 placeholder registers
    wrOpen(8'h09, 8'h02, "R9");
    wrByte(8'h12, 1'b1, "R9 data0");
    wrByte(8'h34, 1'b1, "R9 data1");
    busStop();
    chk("R9 reg9 image", {24'd0, regAt(9)}, 32'h00);
    rdOpen(8'h09, 8'h1F, "R9");
    rdByte(8'h00, 1'b1, "R9 reg9 read");
    rdByte(8'h00, 1'b0, "R9 reg10 read");
    busStop();

    // R10 offset wrap
    wrOpen(8'h1F, 8'h02, "R10");
    wrByte(8'hC3, 1'b1, "R10 data0");
    wrByte(8'h3C, 1'b1, "R10 data1");
    busStop();
    chk("R10 reg31", {24'd0, regAt(31)}, 32'hC3);
    chk("R10 reg0 wrapped", {24'd0, regAt(0)}, 32'h3C);
    rdOpen(8'h1F, 8'h1F, "R10");
    rdByte(8'hC3, 1'b1, "R10 read reg31");
    rdByte(8'h3C, 1'b0, "R10 read reg0");
    busStop();

    // R11 byte cut short by a stop
    wrOpen(8'h1C, 8'h02, "R11");
    wrByte(8'h66, 1'b1, "R11 data0");
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    busStop();
    chk("R11 reg28", {24'd0, regAt(28)}, 32'h66);
    chk("R11 reg29 dropped", {24'd0, regAt(29)}, 32'h00);

    // R6 count byte follows register 8
    wrOpen(8'h08, 8'h01, "R6");
    wrByte(8'h04, 1'b1, "R6 count reg write");
    busStop();
    rdOpen(8'h14, 8'h04, "R6");
    rdByte(8'h11, 1'b1, "R6 reg20");
    rdByte(8'h22, 1'b1, "R6 reg21");
    rdByte(8'h33, 1'b0, "R6 reg22");
    busStop();

    repeat (20) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule